// File: doc/BRIEF.md
# Opcode Prefix Framing FSM

This block sits behind a bus-cycle classifier on a processor that uses single-byte instruction prefixes. Each time a bus cycle ends, the classifier hands it one event made of the cycle kind and the data byte that was on the bus. The FSM groups these events into one instruction's framing fields. These are the accumulated prefix code, the signed displacement (present only in the indexed-bit form, where it comes before the opcode) and the opcode byte. It reports them with a single-cycle strobe.

Prefixes can be chained, and each new prefix replaces the one held before it. Bytes that break the expected framing raise one of three error codes. After an error the FSM goes back to idle and evaluates the same event again, so a fetch that exposed the error can start the next instruction. Looking up instruction attributes and collecting operands are left to later stages.

Top module: `opf_frame_top`

## Requirements
- R1: In idle, events whose kind is not fetch (kind codes: 0 none, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 fetch, 6 interrupt acknowledge) produce no frame and no error.
- R2: In idle, a fetched byte other than 0xCB, 0xED, 0xDD or 0xFD is an opcode. It is framed with prefix code 0x0000 and without a displacement.
- R3: A fetched 0xCB, 0xED, 0xDD or 0xFD in idle is held as a prefix. The next fetched byte that is neither a chain prefix nor an index-bit continuation is framed as the opcode, with prefix code {0x00, prefix}.
- R4: In the prefix state, a valid event whose kind is not fetch raises error code 1 and produces no frame.
- R5: After a held 0xDD or 0xFD, a fetched 0xCB forms the prefix code {held prefix, 0xCB}. The next memory read is the displacement and the memory read after it is the opcode. That frame is reported with frm_has_disp set.
- R6: In the prefix state, a fetched 0xDD, 0xED or 0xFD replaces the held prefix.
- R7: In the indexed-bit form, a displacement event that is not a memory read raises error code 2.
- R8: In the indexed-bit form, an opcode event that is not a memory read raises error code 3.
- R9: An event that raises an error is evaluated again in idle in the same cycle. A non-prefix fetch then frames an opcode with prefix 0x0000 together with the error, and a prefix fetch opens a new prefix state.
- R10: Reset clears both strobes and all output fields. frm_valid and err_valid are high only in the cycle after the clock edge that accepted the causing event. With evt_valid low, the inputs have no effect.
- R11: A fetched 0xCB that follows a held 0xCB or 0xED is an opcode, not a prefix.
- R12: The displacement is a two's-complement byte covering -128 to +127, passed through unchanged on frm_disp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One bus-cycle-end event this clock |
| evt_kind | input | 3 | Kind of the ended cycle (codes in R1) |
| evt_data | input | 8 | Data byte of the ended cycle |
| frm_valid | output | 1 | Framed opcode strobe |
| frm_prefix | output | 16 | Prefix code, 0 when there is no prefix |
| frm_has_disp | output | 1 | Frame carries a displacement |
| frm_disp | output | 8 | Signed displacement |
| frm_opcode | output | 8 | Opcode byte |
| err_valid | output | 1 | Framing error strobe |
| err_code | output | 2 | 1 no fetch after prefix, 2 missing displacement, 3 missing opcode |

## Verification
The assertions take for granted that the classifier delivers at most one event per clock. They also assume the kind code stays in the range 0 to 6 and that evt_kind and evt_data are only meaningful while evt_valid is high, which is what lets the past-cycle checks link a strobe back to the event one edge earlier. The stimulus changes inputs only on the falling edge and uses legal kind codes only. It also toggles evt_valid low while driving a non-fetch kind, to show that such cycles leave the prefix state undisturbed.

// File: rtl/opf_pkg.sv
package opf_pkg;

   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_MEMRD  = 3'd1,
      K_MEMWR  = 3'd2,
      K_IORD   = 3'd3,
      K_IOWR   = 3'd4,
      K_FETCH  = 3'd5,
      K_INTACK = 3'd6
   } bus_kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_PFX,
      S_DISP,
      S_OPC
   } frame_st_e;

   typedef enum logic [1:0] {
      E_NONE    = 2'd0,
      E_NOFETCH = 2'd1,
      E_NODISP  = 2'd2,
      E_NOOPC   = 2'd3
   } frame_err_e;

   localparam logic [7:0] PB_BIT = 8'hCB;
   localparam logic [7:0] PB_EXT = 8'hED;
   localparam logic [7:0] PB_IX  = 8'hDD;
   localparam logic [7:0] PB_IY  = 8'hFD;

endpackage

// File: rtl/opf_byte_class.sv
module opf_byte_class
   import opf_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] code_i,
   output logic              is_pfx_o,
   output logic              is_idx_o,
   output logic              is_bit_o,
   output logic              is_chain_o
);

   // Index prefixes select the form that may carry a displacement.
   assign is_idx_o   = (code_i == PB_IX) || (code_i == PB_IY);
   assign is_bit_o   = (code_i == PB_BIT);
   // Bytes that replace a held prefix.
   assign is_chain_o = is_idx_o || (code_i == PB_EXT);
   assign is_pfx_o   = is_chain_o || is_bit_o;

endmodule

// File: rtl/opf_seq.sv
module opf_seq
   import opf_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int KIND_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_valid,
   input  logic [KIND_W-1:0]     evt_kind,
   input  logic [BYTE_W-1:0]     evt_data,
   output logic                  emit_o,
   output logic [2*BYTE_W-1:0]   emit_pfx_o,
   output logic                  emit_has_disp_o,
   output logic [BYTE_W-1:0]     emit_disp_o,
   output logic                  err_o,
   output logic [1:0]            err_code_o
);

   localparam int PFX_W = 2 * BYTE_W;

   frame_st_e          st_q, st_d, idle_st;
   logic [PFX_W-1:0]   pfx_q, pfx_d, idle_pfx;
   logic               idx_q, idx_d, idle_idx, idle_emit;
   logic [BYTE_W-1:0]  disp_q, disp_d;
   logic               restart;
   frame_err_e         code;
   logic               c_pfx, c_idx, c_bit, c_chain;
   logic               kind_fetch, kind_rd;

   assign kind_fetch = (evt_kind == K_FETCH);
   assign kind_rd    = (evt_kind == K_MEMRD);

   opf_byte_class #(.BYTE_W(BYTE_W)) u_class (
      .code_i     (evt_data),
      .is_pfx_o   (c_pfx),
      .is_idx_o   (c_idx),
      .is_bit_o   (c_bit),
      .is_chain_o (c_chain)
   );

   // What idle would do with this event; reused after an error.
   always_comb begin
      idle_st   = S_IDLE;
      idle_pfx  = '0;
      idle_idx  = 1'b0;
      idle_emit = 1'b0;
      if (kind_fetch) begin
         if (c_pfx) begin
            idle_st  = S_PFX;
            idle_pfx = {{BYTE_W{1'b0}}, evt_data};
            idle_idx = c_idx;
         end else begin
            idle_emit = 1'b1;
         end
      end
   end

   always_comb begin
      st_d            = st_q;
      pfx_d           = pfx_q;
      idx_d           = idx_q;
      disp_d          = disp_q;
      emit_o          = 1'b0;
      emit_pfx_o      = '0;
      emit_has_disp_o = 1'b0;
      err_o           = 1'b0;
      code            = E_NONE;
      restart         = 1'b0;
      if (evt_valid) begin
         unique case (st_q)
            S_IDLE: restart = 1'b1;
            S_PFX: begin
               if (!kind_fetch) begin
                  err_o   = 1'b1;
                  code    = E_NOFETCH;
                  restart = 1'b1;
               end else if (idx_q && c_bit) begin
                  pfx_d = {pfx_q[BYTE_W-1:0], evt_data};
                  st_d  = S_DISP;
               end else if (c_chain) begin
                  pfx_d = {{BYTE_W{1'b0}}, evt_data};
                  idx_d = c_idx;
               end else begin
                  emit_o     = 1'b1;
                  emit_pfx_o = pfx_q;
                  st_d       = S_IDLE;
               end
            end
            S_DISP: begin
               if (!kind_rd) begin
                  err_o   = 1'b1;
                  code    = E_NODISP;
                  restart = 1'b1;
               end else begin
                  disp_d = evt_data;
                  st_d   = S_OPC;
               end
            end
            S_OPC: begin
               if (!kind_rd) begin
                  err_o   = 1'b1;
                  code    = E_NOOPC;
                  restart = 1'b1;
               end else begin
                  emit_o          = 1'b1;
                  emit_pfx_o      = pfx_q;
                  emit_has_disp_o = 1'b1;
                  st_d            = S_IDLE;
               end
            end
            default: restart = 1'b1;
         endcase
         if (restart) begin
            st_d            = idle_st;
            pfx_d           = idle_pfx;
            idx_d           = idle_idx;
            emit_o          = idle_emit;
            emit_pfx_o      = '0;
            emit_has_disp_o = 1'b0;
         end
      end
   end

   assign err_code_o  = code;
   assign emit_disp_o = disp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         pfx_q  <= '0;
         idx_q  <= 1'b0;
         disp_q <= '0;
      end else begin
         st_q   <= st_d;
         pfx_q  <= pfx_d;
         idx_q  <= idx_d;
         disp_q <= disp_d;
      end
   end

   // R1: idle stays idle and silent on non-fetch events
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && evt_valid && !kind_fetch) |=> (st_q == S_IDLE))
      else $error("p_idle_quiet_r1");

   // R5: opcode state is entered only after a displacement read
   p_disp_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_OPC && $past(st_q) != S_OPC) |->
         ($past(evt_valid) && $past(evt_kind) == K_MEMRD && $past(st_q) == S_DISP))
      else $error("p_disp_read_r5");

   // R6: a plain prefix held in the prefix state has an empty upper byte
   p_chain_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_PFX) |-> (pfx_q[PFX_W-1:BYTE_W] == '0))
      else $error("p_chain_narrow_r6");

endmodule

// File: rtl/opf_out_stage.sv
module opf_out_stage #(
   parameter int BYTE_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  emit_i,
   input  logic [2*BYTE_W-1:0]   pfx_i,
   input  logic                  has_disp_i,
   input  logic [BYTE_W-1:0]     disp_i,
   input  logic [BYTE_W-1:0]     opcode_i,
   input  logic                  err_i,
   input  logic [1:0]            err_code_i,
   output logic                  frm_valid_o,
   output logic [2*BYTE_W-1:0]   frm_prefix_o,
   output logic                  frm_has_disp_o,
   output logic [BYTE_W-1:0]     frm_disp_o,
   output logic [BYTE_W-1:0]     frm_opcode_o,
   output logic                  err_valid_o,
   output logic [1:0]            err_code_o
);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               frm_valid_o    <= 1'b0;
               frm_prefix_o   <= '0;
               frm_has_disp_o <= 1'b0;
               frm_disp_o     <= '0;
               frm_opcode_o   <= '0;
               err_valid_o    <= 1'b0;
               err_code_o     <= '0;
            end else begin
               frm_valid_o <= emit_i;
               err_valid_o <= err_i;
               if (emit_i) begin
                  frm_prefix_o   <= pfx_i;
                  frm_has_disp_o <= has_disp_i;
                  frm_disp_o     <= disp_i;
                  frm_opcode_o   <= opcode_i;
               end
               if (err_i) begin
                  err_code_o <= err_code_i;
               end
            end
         end
      end else begin : g_comb
         assign frm_valid_o    = emit_i;
         assign frm_prefix_o   = pfx_i;
         assign frm_has_disp_o = has_disp_i;
         assign frm_disp_o     = disp_i;
         assign frm_opcode_o   = opcode_i;
         assign err_valid_o    = err_i;
         assign err_code_o     = err_code_i;
      end
   endgenerate

endmodule

// File: rtl/opf_frame_top.sv
module opf_frame_top
   import opf_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int KIND_W  = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      evt_valid,
   input  logic [KIND_W-1:0]         evt_kind,
   input  logic [BYTE_W-1:0]         evt_data,
   output logic                      frm_valid,
   output logic [2*BYTE_W-1:0]       frm_prefix,
   output logic                      frm_has_disp,
   output logic signed [BYTE_W-1:0]  frm_disp,
   output logic [BYTE_W-1:0]         frm_opcode,
   output logic                      err_valid,
   output logic [1:0]                err_code
);

   localparam int PFX_W = 2 * BYTE_W;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("opf_frame_top: prefix codes are byte values, BYTE_W must be 8");
      end
      if (KIND_W != 3) begin : g_bad_kind
         $error("opf_frame_top: cycle kind code needs KIND_W of 3");
      end
   endgenerate

   logic               emit, has_disp, err;
   logic [PFX_W-1:0]   emit_pfx;
   logic [BYTE_W-1:0]  disp;
   logic [1:0]         code;
   logic [BYTE_W-1:0]  disp_raw;

   opf_seq #(.BYTE_W(BYTE_W), .KIND_W(KIND_W)) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .evt_valid       (evt_valid),
      .evt_kind        (evt_kind),
      .evt_data        (evt_data),
      .emit_o          (emit),
      .emit_pfx_o      (emit_pfx),
      .emit_has_disp_o (has_disp),
      .emit_disp_o     (disp),
      .err_o           (err),
      .err_code_o      (code)
   );

   opf_out_stage #(.BYTE_W(BYTE_W), .OUT_REG(OUT_REG)) u_out (
      .clk            (clk),
      .rst_n          (rst_n),
      .emit_i         (emit),
      .pfx_i          (emit_pfx),
      .has_disp_i     (has_disp),
      .disp_i         (disp),
      .opcode_i       (evt_data),
      .err_i          (err),
      .err_code_i     (code),
      .frm_valid_o    (frm_valid),
      .frm_prefix_o   (frm_prefix),
      .frm_has_disp_o (frm_has_disp),
      .frm_disp_o     (disp_raw),
      .frm_opcode_o   (frm_opcode),
      .err_valid_o    (err_valid),
      .err_code_o     (err_code)
   );

   assign frm_disp = $signed(disp_raw);

   // R4: an error strobe always carries a nonzero code
   p_err_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (err_code != 2'd0))
      else $error("p_err_code_r4");

   // R5: a displacement frame carries an index prefix followed by 0xCB
   p_disp_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_has_disp) |->
         (frm_prefix[BYTE_W-1:0] == PB_BIT &&
          (frm_prefix[PFX_W-1:BYTE_W] == PB_IX || frm_prefix[PFX_W-1:BYTE_W] == PB_IY)))
      else $error("p_disp_form_r5");

   // R3: frames without displacement carry at most one prefix byte
   p_narrow_pfx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !frm_has_disp) |-> (frm_prefix[PFX_W-1:BYTE_W] == '0))
      else $error("p_narrow_pfx_r3");

   generate
      if (OUT_REG) begin : g_timed_chk
         // R10: strobes follow an accepted event by one edge
         p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (frm_valid || err_valid) |-> $past(evt_valid))
            else $error("p_pulse_r10");

         // R7: a missing-displacement error never follows a memory read
         p_nodisp_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (err_valid && err_code == 2'd2) |-> ($past(evt_kind) != K_MEMRD))
            else $error("p_nodisp_src_r7");

         // R2: an unprefixed frame comes from a fetch of that very byte
         p_plain_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (frm_valid && frm_prefix == '0) |->
               ($past(evt_kind) == K_FETCH && frm_opcode == $past(evt_data)))
            else $error("p_plain_fetch_r2");
      end
   endgenerate

endmodule

// File: tb/opf_frame_top_tb.sv
module opf_frame_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [2:0]  evt_kind = 3'd0;
   logic [7:0]  evt_data = 8'h00;
   logic        frm_valid, frm_has_disp, err_valid;
   logic [15:0] frm_prefix;
   logic signed [7:0] frm_disp;
   logic [7:0]  frm_opcode;
   logic [1:0]  err_code;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   opf_frame_top u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_valid    (evt_valid),
      .evt_kind     (evt_kind),
      .evt_data     (evt_data),
      .frm_valid    (frm_valid),
      .frm_prefix   (frm_prefix),
      .frm_has_disp (frm_has_disp),
      .frm_disp     (frm_disp),
      .frm_opcode   (frm_opcode),
      .err_valid    (err_valid),
      .err_code     (err_code)
   );

   // {req, kind, data, exp frame, exp prefix, exp has_disp, exp disp, exp err, exp code}
   // kinds: 1 memrd, 2 memwr, 3 iord, 5 fetch, 6 intack
   localparam int NV = 46;
   localparam logic [43:0] VEC [NV] = '{
      {4'd2, 3'd5,8'h3E, 1'b1,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R2 plain opcode
      {4'd1, 3'd1,8'h12, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R1 read ignored
      {4'd1, 3'd2,8'h00, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R1 write ignored
      {4'd1, 3'd6,8'hFF, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R1 intack ignored
      {4'd3, 3'd5,8'hED, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R3 prefix
      {4'd3, 3'd5,8'hB0, 1'b1,16'h00ED,1'b0,8'h00, 1'b0,2'd0}, // R3 framed
      {4'd6, 3'd5,8'hDD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R6 chain start
      {4'd6, 3'd5,8'hFD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R6 replace
      {4'd6, 3'd5,8'h21, 1'b1,16'h00FD,1'b0,8'h00, 1'b0,2'd0}, // R6 last prefix wins
      {4'd5, 3'd5,8'hDD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R5
      {4'd5, 3'd5,8'hCB, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R5 two-byte prefix
      {4'd12,3'd1,8'h80, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R12 disp -128
      {4'd12,3'd1,8'h46, 1'b1,16'hDDCB,1'b1,8'h80, 1'b0,2'd0}, // R12 R5 framed
      {4'd5, 3'd5,8'hFD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R5
      {4'd5, 3'd5,8'hCB, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R5
      {4'd12,3'd1,8'h7F, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R12 disp +127
      {4'd12,3'd1,8'h0E, 1'b1,16'hFDCB,1'b1,8'h7F, 1'b0,2'd0}, // R12 framed
      {4'd11,3'd5,8'hCB, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R11
      {4'd11,3'd5,8'hCB, 1'b1,16'h00CB,1'b0,8'h00, 1'b0,2'd0}, // R11 CB after CB
      {4'd11,3'd5,8'hED, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R11
      {4'd11,3'd5,8'hCB, 1'b1,16'h00ED,1'b0,8'h00, 1'b0,2'd0}, // R11 CB after ED
      {4'd4, 3'd5,8'hDD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R4
      {4'd4, 3'd1,8'h05, 1'b0,16'h0000,1'b0,8'h00, 1'b1,2'd1}, // R4 read after prefix
      {4'd4, 3'd5,8'hFD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R4
      {4'd4, 3'd3,8'h05, 1'b0,16'h0000,1'b0,8'h00, 1'b1,2'd1}, // R4 io read after prefix
      {4'd7, 3'd5,8'hDD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R7
      {4'd7, 3'd5,8'hCB, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R7
      {4'd9, 3'd5,8'h10, 1'b1,16'h0000,1'b0,8'h00, 1'b1,2'd2}, // R9 R7 fetch reused
      {4'd7, 3'd5,8'hDD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R7
      {4'd7, 3'd5,8'hCB, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R7
      {4'd7, 3'd2,8'h01, 1'b0,16'h0000,1'b0,8'h00, 1'b1,2'd2}, // R7 write as disp
      {4'd8, 3'd5,8'hDD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd8, 3'd5,8'hCB, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd8, 3'd1,8'hFE, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd9, 3'd5,8'h46, 1'b1,16'h0000,1'b0,8'h00, 1'b1,2'd3}, // R9 R8 fetch reused
      {4'd8, 3'd5,8'hFD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd8, 3'd5,8'hCB, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd8, 3'd1,8'h01, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd9, 3'd5,8'hDD, 1'b0,16'h0000,1'b0,8'h00, 1'b1,2'd3}, // R9 error opens prefix
      {4'd9, 3'd5,8'h09, 1'b1,16'h00DD,1'b0,8'h00, 1'b0,2'd0}, // R9 new frame
      {4'd4, 3'd5,8'hED, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R4
      {4'd4, 3'd6,8'h00, 1'b0,16'h0000,1'b0,8'h00, 1'b1,2'd1}, // R4 intack after prefix
      {4'd8, 3'd5,8'hDD, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd8, 3'd5,8'hCB, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd8, 3'd1,8'h00, 1'b0,16'h0000,1'b0,8'h00, 1'b0,2'd0}, // R8
      {4'd8, 3'd2,8'h00, 1'b0,16'h0000,1'b0,8'h00, 1'b1,2'd3}  // R8 write as opcode
   };

   // Drive one cycle from the falling edge; sample 2 ns after the next rising edge.
   task automatic step(input logic v, input logic [2:0] k, input logic [7:0] d);
      @(negedge clk);
      evt_valid = v;
      evt_kind  = k;
      evt_data  = d;
      @(posedge clk);
      #2;
   endtask

   task automatic check(input int req, input logic fv, input logic [15:0] pfx,
                        input logic hd, input logic [7:0] dsp, input logic [7:0] op,
                        input logic ev, input logic [1:0] cd);
      bit bad;
      bad = (frm_valid !== fv) || (err_valid !== ev);
      if (fv && !bad)
         bad = (frm_prefix !== pfx) || (frm_has_disp !== hd) || (frm_opcode !== op) ||
               (hd && (frm_disp !== $signed(dsp)));
      if (ev && !bad)
         bad = (err_code !== cd);
      n_tests++;
      if (bad) begin
         n_fail++;
         $display("FAIL R%0d: got fv=%b pfx=%h hd=%b disp=%h op=%h ev=%b code=%0d, expected fv=%b pfx=%h hd=%b disp=%h op=%h ev=%b code=%0d",
                  req, frm_valid, frm_prefix, frm_has_disp, frm_disp, frm_opcode, err_valid, err_code,
                  fv, pfx, hd, dsp, op, ev, cd);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R10: reset state of every output
      n_tests++;
      if (frm_valid !== 1'b0 || err_valid !== 1'b0 || frm_prefix !== 16'h0 ||
          frm_has_disp !== 1'b0 || frm_disp !== 8'sh0 || frm_opcode !== 8'h0 || err_code !== 2'd0) begin
         n_fail++;
         $display("FAIL R10: reset outputs fv=%b ev=%b pfx=%h op=%h code=%0d, expected all zero",
                  frm_valid, err_valid, frm_prefix, frm_opcode, err_code);
      end
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [43:0] w;
         w = VEC[i];
         step(1'b1, w[39:37], w[36:29]);
         check(int'(w[43:40]), w[28], w[27:12], w[11], w[10:3], w[36:29], w[2], w[1:0]);
      end

      // R10: strobes drop when no event arrives
      step(1'b0, 3'd5, 8'h3E);
      check(10, 1'b0, 16'h0, 1'b0, 8'h0, 8'h0, 1'b0, 2'd0);

      // R10/R4: with evt_valid low, a non-fetch kind leaves the prefix state alone
      step(1'b1, 3'd5, 8'hDD);
      check(4, 1'b0, 16'h0, 1'b0, 8'h0, 8'h0, 1'b0, 2'd0);
      for (int j = 0; j < 3; j++) begin
         step(1'b0, 3'd1, 8'h99);
         check(10, 1'b0, 16'h0, 1'b0, 8'h0, 8'h0, 1'b0, 2'd0);
      end
      step(1'b1, 3'd5, 8'h77);
      check(10, 1'b1, 16'h00DD, 1'b0, 8'h0, 8'h77, 1'b0, 2'd0);

      // R10: reset in the middle of an indexed-bit frame returns to idle
      step(1'b1, 3'd5, 8'hFD);
      step(1'b1, 3'd5, 8'hCB);
      @(negedge clk);
      evt_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 3'd5, 8'h55);
      check(10, 1'b1, 16'h0000, 1'b0, 8'h0, 8'h55, 1'b0, 2'd0);

      // R2: a single-cycle strobe, then silence
      step(1'b0, 3'd0, 8'h00);
      check(2, 1'b0, 16'h0, 1'b0, 8'h0, 8'h0, 1'b0, 2'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule